// File: doc/BRIEF.md
# Serial Flash Full-Erase Sequencer

This block runs a complete bulk erase of an attached serial flash over a four-wire SPI link, acting as the bus master. A single-cycle request on `start` sets off a fixed sequence of transactions. First it sends the write-enable command. Then it reads the status byte once to confirm that the write-enable latch took. Next it sends the erase opcode. Finally it holds one status-read transaction open until the device reports that it is idle.

The block reports the outcome as a one-cycle pulse on `done` or on `error`. An error arises in two cases: the latch was not set, or the device stayed busy for too many status bytes. Chip select is released after every command so that the device acts on it. A minimum deselect time is also enforced between transactions.

The serial clock runs in mode 0. It idles low, the device output is sampled on the rising edge and data is shifted out on the falling edge. Its half period is a parameter counted in system clocks.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, and `done` and `error` are 0.
- R2: A `start` pulse in idle opens a transaction that carries only the byte 0x06, sent most significant bit first over 8 serial clocks, after which `spi_cs_n` returns high.
- R3: The next transaction is opcode 0x05 followed by exactly one status byte. If bit 1 of that byte (the write-enable latch) is 0, `error` pulses and no further transaction takes place.
- R4: If the latch bit is 1, the next transaction carries only the byte `ERASE_OP` (default 0x60).
- R5: The following transaction is opcode 0x05 with chip select held low while status bytes are read back to back. At the first byte whose bit 0 (busy) is 0, chip select rises and `done` pulses.
- R6: If `POLL_LIMIT` consecutive status bytes all show busy, chip select rises after the last of them and `error` pulses. A byte that is not busy in position `POLL_LIMIT` still gives `done`.
- R7: `spi_cs_n` stays high for at least `CS_HIGH_MIN` system clocks before every falling edge. This includes the first transaction of a new run.
- R8: `done` and `error` are each high for a single cycle per run and never together.
- R9: A `start` pulse while a run is in progress has no effect; the run still produces exactly the transaction sequence above.
- R10: `spi_sck` is 0 whenever no byte is being shifted, and each high or low phase lasts `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin an erase run |
| done | output | 1 | One-cycle pulse: device reported idle after the erase |
| error | output | 1 | One-cycle pulse: latch not set, or busy timeout |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest behaviour to reach from the ports is the edge of the busy timeout. The device must stay busy for exactly `POLL_LIMIT` status bytes in one case and for one byte fewer in the other, and both must happen inside a single open read. The bench therefore contains a behavioural flash model. It counts the status bytes it returns during an erase and clears busy after a count set by each test. This lets the bench place the idle byte on the last allowed position and also past it. The same model can refuse the write-enable, which reaches the error path that skips the erase.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_CHK_OP,
    ST_CHK_RD,
    ST_ERASE,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_GAP
  } seq_state_t;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] FILL_BYTE    = 8'h00;

  // Selects one flag out of a received status byte.
  function automatic logic flag_at(input logic [7:0] status, input int idx);
    return status[idx];
  endfunction

  // Opcode that opens the transaction belonging to a given state.
  function automatic logic [7:0] opcode_for(input seq_state_t st, input logic [7:0] erase_op);
    case (st)
      ST_WREN:  return OP_WR_ENABLE;
      ST_ERASE: return erase_op;
      default:  return OP_RD_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/erase_spi_shifter.sv
module erase_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       active
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;
  logic          half_tick;

  assign half_tick = active && (div_cnt == DIV_LAST);
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bit_idx   <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        div_cnt <= '0;
        bit_idx <= '0;
        sck     <= 1'b0;
        tx_sh   <= tx_byte;
        mosi    <= tx_byte[7];
      end else if (active) begin
        if (half_tick) begin
          div_cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
              mosi    <= tx_sh[6];
            end
          end
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
    end
  end

  assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !active);

endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import flash_erase_pkg::*;
#(
  parameter logic [7:0] ERASE_OP    = 8'h60,
  parameter int         CS_HIGH_MIN = 4,
  parameter int         POLL_LIMIT  = 64,
  parameter int         BUSY_BIT    = 0,
  parameter int         WEL_BIT     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  output logic       go,
  output logic [7:0] tx_byte,
  output logic       cs_n,
  output logic       done,
  output logic       error
);
  localparam int GW = $clog2(CS_HIGH_MIN + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(CS_HIGH_MIN - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  seq_state_t    state, after_gap;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic          wel_seen, busy_seen, gap_over, poll_spent;

  assign wel_seen   = flag_at(rx_byte, WEL_BIT);
  assign busy_seen  = flag_at(rx_byte, BUSY_BIT);
  assign gap_over   = (gap_cnt == GAP_LAST);
  assign poll_spent = (poll_cnt == POLL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_gap <= ST_IDLE;
      gap_cnt   <= '0;
      poll_cnt  <= '0;
      go        <= 1'b0;
      tx_byte   <= FILL_BYTE;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      go    <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cs_n    <= 1'b0;
          go      <= 1'b1;
          tx_byte <= opcode_for(ST_WREN, ERASE_OP);
          state   <= ST_WREN;
        end
        ST_WREN: if (byte_done) begin
          cs_n      <= 1'b1;
          gap_cnt   <= '0;
          after_gap <= ST_CHK_OP;
          state     <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_over) begin
            state <= after_gap;
            if (after_gap != ST_IDLE) begin
              cs_n    <= 1'b0;
              go      <= 1'b1;
              tx_byte <= opcode_for(after_gap, ERASE_OP);
            end
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        ST_CHK_OP: if (byte_done) begin
          go      <= 1'b1;
          tx_byte <= FILL_BYTE;
          state   <= ST_CHK_RD;
        end
        ST_CHK_RD: if (byte_done) begin
          cs_n    <= 1'b1;
          gap_cnt <= '0;
          state   <= ST_GAP;
          if (wel_seen) begin
            after_gap <= ST_ERASE;
          end else begin
            error     <= 1'b1;
            after_gap <= ST_IDLE;
          end
        end
        ST_ERASE: if (byte_done) begin
          cs_n      <= 1'b1;
          gap_cnt   <= '0;
          after_gap <= ST_POLL_OP;
          state     <= ST_GAP;
        end
        ST_POLL_OP: if (byte_done) begin
          go       <= 1'b1;
          tx_byte  <= FILL_BYTE;
          poll_cnt <= '0;
          state    <= ST_POLL_RD;
        end
        ST_POLL_RD: if (byte_done) begin
          if (!busy_seen || poll_spent) begin
            cs_n      <= 1'b1;
            done      <= !busy_seen;
            error     <= busy_seen;
            gap_cnt   <= '0;
            after_gap <= ST_IDLE;
            state     <= ST_GAP;
          end else begin
            poll_cnt <= poll_cnt + PW'(1);
            go       <= 1'b1;
            tx_byte  <= FILL_BYTE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent count of deselect time, used only by the gap check.
  logic [GW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 hi_run <= GW'(CS_HIGH_MIN);
    else if (!cs_n)                             hi_run <= '0;
    else if (hi_run < GW'(CS_HIGH_MIN))         hi_run <= hi_run + GW'(1);
  end

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_run >= GW'(CS_HIGH_MIN)));

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error));

  assert_poll_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL_RD) |-> !cs_n);

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL_RD) |-> (poll_cnt <= POLL_LAST));

  assert_entry_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_WREN) |=> (state != ST_WREN));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int         CLK_DIV     = 2,
  parameter logic [7:0] ERASE_OP    = 8'h60,
  parameter int         CS_HIGH_MIN = 4,
  parameter int         POLL_LIMIT  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done,
  output logic error,
  output logic spi_cs_n,
  output logic spi_sck,
  output logic spi_mosi,
  input  logic spi_miso
);
  logic       xfer_go;
  logic       byte_done;
  logic       shift_active;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;

  erase_seq_fsm #(
    .ERASE_OP   (ERASE_OP),
    .CS_HIGH_MIN(CS_HIGH_MIN),
    .POLL_LIMIT (POLL_LIMIT),
    .BUSY_BIT   (0),
    .WEL_BIT    (1)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .go       (xfer_go),
    .tx_byte  (tx_byte),
    .cs_n     (spi_cs_n),
    .done     (done),
    .error    (error)
  );

  erase_spi_shifter #(
    .CLK_DIV(CLK_DIV)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (xfer_go),
    .tx_byte  (tx_byte),
    .miso     (spi_miso),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .active   (shift_active)
  );

  assert_sck_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_shift_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_active |-> !spi_cs_n);

endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int         CLK_DIV     = 2;
  localparam int         CS_HIGH_MIN = 3;
  localparam int         POLL_LIMIT  = 8;
  localparam logic [7:0] ERASE_OP    = 8'h60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, error, spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #2 clk = ~clk;

  flash_erase_seq #(
    .CLK_DIV(CLK_DIV), .ERASE_OP(ERASE_OP),
    .CS_HIGH_MIN(CS_HIGH_MIN), .POLL_LIMIT(POLL_LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural flash: records each transaction's first byte and length.
  int         m_bits = 0;
  logic [7:0] m_in = 0, m_cmd = 0, m_out = 0;
  bit         m_wel = 0, m_busy = 0, wren_ok = 1;
  int         m_left = 0, busy_len = 0;
  int         txn = 0;
  int         t_op[16];
  int         t_len[16];

  assign spi_miso = m_out[7];

  always @(negedge spi_cs_n) begin
    m_bits = 0;
    m_cmd  = 8'h00;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    m_in = {m_in[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) m_cmd = m_in;
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (m_bits > 0 && (m_bits % 8) == 0 && m_cmd == 8'h05) begin
      m_out = {6'b0, m_wel, m_busy};
      if (m_busy) begin
        if (m_left <= 1) m_busy = 0;
        else m_left--;
      end
    end else begin
      m_out = {m_out[6:0], 1'b0};
    end
  end

  always @(posedge spi_cs_n) if (m_bits >= 8) begin
    if (txn < 16) begin
      t_op[txn]  = m_cmd;
      t_len[txn] = m_bits / 8;
    end
    txn++;
    if (m_cmd == 8'h06 && wren_ok) m_wel = 1;
    if (m_cmd == ERASE_OP && m_wel) begin
      m_busy = 1;
      m_left = busy_len;
      m_wel  = 0;
    end
    m_bits = 0;
  end

  // Port monitors: deselect gaps, clock phases, pulse widths.
  int  cs_hi_run = 0, min_gap = 1000, sck_hi = 0, sck_lo = 0;
  int  ph_min = 1000, ph_max = 0, done_run = 0, err_run = 0, pulse_max = 0;
  bit  seen_low = 0, both_seen = 0;

  always @(posedge clk) if (rst_n) begin
    if (spi_cs_n) cs_hi_run++;
    else begin
      if (cs_hi_run > 0 && seen_low && cs_hi_run < min_gap) min_gap = cs_hi_run;
      if (cs_hi_run > 0) seen_low = 1;
      cs_hi_run = 0;
    end
    if (spi_sck) begin
      sck_hi++;
      if (sck_lo > 0 && !spi_cs_n) begin
        if (sck_lo < ph_min && sck_lo < 100) ph_min = sck_lo;
      end
      sck_lo = 0;
    end else begin
      if (sck_hi > 0) begin
        if (sck_hi < ph_min) ph_min = sck_hi;
        if (sck_hi > ph_max) ph_max = sck_hi;
      end
      sck_hi = 0;
      if (!spi_cs_n) sck_lo++;
    end
    done_run = done  ? done_run + 1 : 0;
    err_run  = error ? err_run + 1 : 0;
    if (done_run > pulse_max) pulse_max = done_run;
    if (err_run > pulse_max) pulse_max = err_run;
    if (done && error) both_seen = 1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  int  got_done, got_err;

  task automatic run_once(input int blen, input bit accept, input bit extra_starts);
    txn = 0; m_wel = 0; m_busy = 0; m_left = 0;
    busy_len = blen; wren_ok = accept;
    got_done = 0; got_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (extra_starts && i < 150) start = (i % 3 == 0);
      else start = 1'b0;
      if (done)  got_done++;
      if (error) got_err++;
      @(negedge clk);
      if (got_done + got_err > 0 && i > 200) break;
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(error === 1'b0, "R1 error", error, 0);
  endtask

  task automatic test_normal();
    run_once(3, 1, 0);
    chk(got_done == 1, "R5 done count", got_done, 1);
    chk(got_err == 0, "R8 no error", got_err, 0);
    chk(txn == 4, "R5 txn count", txn, 4);
    chk(t_op[0] == 8'h06 && t_len[0] == 1, "R2 wren alone", t_op[0], 8'h06);
    chk(t_op[1] == 8'h05 && t_len[1] == 2, "R3 check read", t_len[1], 2);
    chk(t_op[2] == ERASE_OP && t_len[2] == 1, "R4 erase op", t_op[2], ERASE_OP);
    chk(t_op[3] == 8'h05, "R5 poll opcode", t_op[3], 8'h05);
    chk(t_len[3] == 5, "R5 poll length", t_len[3], 5);
  endtask

  task automatic test_no_latch();
    run_once(3, 0, 0);
    chk(got_err == 1, "R3 error pulse", got_err, 1);
    chk(got_done == 0, "R3 no done", got_done, 0);
    chk(txn == 2, "R3 stops before erase", txn, 2);
  endtask

  task automatic test_timeout();
    run_once(20, 1, 0);
    chk(got_err == 1, "R6 timeout error", got_err, 1);
    chk(got_done == 0, "R6 no done", got_done, 0);
    chk(t_len[3] == 1 + POLL_LIMIT, "R6 poll bytes", t_len[3], 1 + POLL_LIMIT);
  endtask

  task automatic test_last_byte();
    run_once(POLL_LIMIT - 1, 1, 0);
    chk(got_done == 1, "R6 clear on last byte", got_done, 1);
    chk(got_err == 0, "R6 no error", got_err, 0);
    chk(t_len[3] == 1 + POLL_LIMIT, "R6 poll bytes", t_len[3], 1 + POLL_LIMIT);
  endtask

  task automatic test_start_ignored();
    run_once(2, 1, 1);
    chk(txn == 4, "R9 txn count", txn, 4);
    chk(t_op[0] == 8'h06 && t_op[2] == ERASE_OP, "R9 sequence", t_op[2], ERASE_OP);
    chk(got_done == 1, "R9 single done", got_done, 1);
  endtask

  task automatic test_back_to_back();
    int lo_at;
    txn = 0; m_wel = 0; m_busy = 0; busy_len = 1; wren_ok = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    lo_at = 0;
    start = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!spi_cs_n) begin lo_at = i + 1; break; end
    end
    start = 1'b0;
    chk(lo_at >= CS_HIGH_MIN, "R7 restart gap", lo_at, CS_HIGH_MIN);
    while (!(done || error)) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_normal();
    test_no_latch();
    test_timeout();
    test_last_byte();
    test_start_ignored();
    test_back_to_back();
    chk(min_gap >= CS_HIGH_MIN, "R7 min deselect", min_gap, CS_HIGH_MIN);
    chk(ph_min == CLK_DIV && ph_max == CLK_DIV, "R10 sck phase", ph_min, CLK_DIV);
    chk(pulse_max == 1, "R8 pulse width", pulse_max, 1);
    chk(!both_seen, "R8 exclusive", both_seen, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule